// File: doc/BRIEF.md
# Non-Posted Request Credit Gate

The gate sits in a receive path between a packet source and user logic. Every packet arrives as one transfer, tagged as posted or non-posted. Posted packets go straight to a single registered output slot. Non-posted packets first enter a small holding queue. They leave that queue only while the user has granted credit.

The user adds credit with a 2-bit code every clock. The code does not have to line up with packet transfers. The count is capped and is visible on a 6-bit output. While credit is zero, held non-posted packets wait in the queue, and posted packets behind them overtake. The count is cleared by the synchronous reset, and it is also cleared whenever the link-up flag is low.

Top module: `np_credit_gate`

## Requirements
- R1: The credit code sampled at each clock edge adds credit as follows: `00` adds 0, `01` adds 1, and `10` or `11` add 2. The new count appears on `credit_cnt` after that edge.
- R2: The count never exceeds 32. The increment and the decrement of the same cycle are summed first, and the cap is applied to that sum. With the count at 32, code `01` and one delivery in the same cycle leave it at 32.
- R3: Each non-posted packet loaded into the output slot lowers the count by one.
- R4: A non-posted packet is never loaded while the count is zero. Up to NP_DEPTH non-posted packets wait in the queue. With the queue full, `in_ready` is low for a non-posted input.
- R5: Posted packets are accepted and forwarded while non-posted packets wait for credit, so posted packets overtake them.
- R6: After the synchronous reset `rst`, the count is 0 and `out_valid` is 0.
- R7: While `link_up` is low, the count is 0 one cycle later and credit codes have no effect.
- R8: While `out_valid` is high and `out_ready` is low, `out_data` and `out_posted` hold their values, and no new packet is accepted into the slot.
- R9: Non-posted packets leave in the order they arrived.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| link_up | input | 1 | Link-up flag; a low level clears the credit count |
| credit_req | input | 2 | Per-cycle credit code (00:+0, 01:+1, 1x:+2) |
| in_valid | input | 1 | Input packet valid |
| in_ready | output | 1 | Input packet accepted this cycle |
| in_posted | input | 1 | 1 = posted packet, 0 = non-posted packet |
| in_data | input | DATA_W | Input packet payload |
| out_valid | output | 1 | Output slot holds a packet |
| out_ready | input | 1 | User takes the packet in the slot |
| out_posted | output | 1 | Posted flag of the packet in the slot |
| out_data | output | DATA_W | Payload of the packet in the slot |
| credit_cnt | output | 6 | Registered credit count |

## Verification
The credit codes are applied one at a time and in long runs of `11`. This separates the rule that `10` and `11` are equal from saturation. A delivery made with the count pinned at 32 and code `01` held shows whether the cap is applied to the summed change or before the decrement.

Traffic with zero credit and mixed posted/non-posted packets shows that posted packets overtake held ones, and that the queue applies backpressure when full. Back-to-back non-posted bursts with known credit check the per-delivery decrement and the arrival order. A stalled output slot checks the hold rule.

// File: rtl/np_gate_pkg.sv
package np_gate_pkg;
  localparam int CREDIT_MAX = 32;
  localparam int CNT_W      = $clog2(CREDIT_MAX + 1);

  typedef enum logic [1:0] {
    CR_NONE  = 2'b00,
    CR_ONE   = 2'b01,
    CR_TWO   = 2'b10,
    CR_TWO_B = 2'b11
  } credit_code_e;

  function automatic logic [1:0] code_to_inc(logic [1:0] code);
    case (credit_code_e'(code))
      CR_NONE: return 2'd0;
      CR_ONE:  return 2'd1;
      default: return 2'd2;
    endcase
  endfunction
endpackage

// File: rtl/np_credit_ctr.sv
module np_credit_ctr #(
  parameter int MAX = 32,
  parameter int CW  = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          link_up,
  input  logic [1:0]    req,
  input  logic          take,
  output logic [CW-1:0] cnt,
  output logic          has_credit
);
  localparam int SW = CW + 1;

  logic [SW-1:0] sum;
  logic [CW-1:0] cnt_nxt;

  always_comb begin
    sum     = {1'b0, cnt} + SW'(np_gate_pkg::code_to_inc(req)) - SW'(take);
    cnt_nxt = (sum > SW'(MAX)) ? CW'(MAX) : sum[CW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst || !link_up) cnt <= '0;
    else                 cnt <= cnt_nxt;
  end

  assign has_credit = (cnt != '0);

  AST_CNT_CEIL: assert property (@(posedge clk) disable iff (rst) cnt <= CW'(MAX)); // R2
  AST_TAKE_NEEDS_CREDIT: assert property (@(posedge clk) disable iff (rst) take |-> cnt != '0); // R4
  AST_LINK_CLEAR: assert property (@(posedge clk) disable iff (rst) !link_up |=> cnt == '0); // R7
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst) (link_up && req == 2'b00 && !take) |=> cnt == $past(cnt)); // R1
  AST_TAKE_DROP: assert property (@(posedge clk) disable iff (rst) (link_up && req == 2'b00 && take) |=> cnt == $past(cnt) - 1'b1); // R3
endmodule

// File: rtl/np_hold_fifo.sv
module np_hold_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int NW = AW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [NW-1:0] fill;

  function automatic logic [AW-1:0] bump(logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp   <= '0;
      rp   <= '0;
      fill <= '0;
    end else begin
      if (push) wp <= bump(wp);
      if (pop)  rp <= bump(rp);
      fill <= fill + NW'(push) - NW'(pop);
    end
  end

  assign dout  = mem[rp];
  assign empty = (fill == '0);
  assign full  = (fill == NW'(DEPTH));

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst) push |-> !full); // R4
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst) pop |-> !empty); // R9
endmodule

// File: rtl/np_out_stage.sv
module np_out_stage #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] ld_data,
  input  logic         ld_posted,
  input  logic         out_ready,
  output logic         out_valid,
  output logic [W-1:0] out_data,
  output logic         out_posted,
  output logic         slot_free
);
  assign slot_free = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
    end else if (load) begin
      out_valid <= 1'b1;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (load) begin
      out_data   <= ld_data;
      out_posted <= ld_posted;
    end
  end

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst) (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_posted))); // R8
  AST_LOAD_FREE: assert property (@(posedge clk) disable iff (rst) load |-> slot_free); // R8
endmodule

// File: rtl/np_credit_gate.sv
module np_credit_gate #(
  parameter int DATA_W   = 32,
  parameter int NP_DEPTH = 4
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          link_up,
  input  logic [1:0]                    credit_req,
  input  logic                          in_valid,
  output logic                          in_ready,
  input  logic                          in_posted,
  input  logic [DATA_W-1:0]             in_data,
  output logic                          out_valid,
  input  logic                          out_ready,
  output logic                          out_posted,
  output logic [DATA_W-1:0]             out_data,
  output logic [np_gate_pkg::CNT_W-1:0] credit_cnt
);
  import np_gate_pkg::*;

  logic              np_push, np_empty, np_full;
  logic [DATA_W-1:0] np_head;
  logic              has_credit, slot_free;
  logic              np_go, post_go, load;
  logic [DATA_W-1:0] ld_data;

  assign np_push = in_valid && !in_posted && !np_full;
  assign np_go   = slot_free && !np_empty && has_credit && link_up;
  assign post_go = slot_free && !np_go && in_valid && in_posted;
  assign load    = np_go || post_go;
  assign ld_data = np_go ? np_head : in_data;

  assign in_ready = in_posted ? (slot_free && !np_go) : !np_full;

  np_hold_fifo #(.W(DATA_W), .DEPTH(NP_DEPTH)) u_hold (
    .clk   (clk),
    .rst   (rst),
    .push  (np_push),
    .din   (in_data),
    .pop   (np_go),
    .dout  (np_head),
    .empty (np_empty),
    .full  (np_full)
  );

  np_credit_ctr #(.MAX(CREDIT_MAX), .CW(CNT_W)) u_ctr (
    .clk        (clk),
    .rst        (rst),
    .link_up    (link_up),
    .req        (credit_req),
    .take       (np_go),
    .cnt        (credit_cnt),
    .has_credit (has_credit)
  );

  np_out_stage #(.W(DATA_W)) u_out (
    .clk        (clk),
    .rst        (rst),
    .load       (load),
    .ld_data    (ld_data),
    .ld_posted  (!np_go),
    .out_ready  (out_ready),
    .out_valid  (out_valid),
    .out_data   (out_data),
    .out_posted (out_posted),
    .slot_free  (slot_free)
  );

  AST_RESET_STATE: assert property (@(posedge clk) rst |=> (!out_valid && credit_cnt == '0)); // R6
  AST_POSTED_FLOWS: assert property (@(posedge clk) disable iff (rst) (!has_credit && in_valid && in_posted && out_ready) |-> in_ready); // R5
endmodule

// File: tb/np_credit_gate_tb.sv
module np_credit_gate_tb;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst, link_up, in_valid, in_posted, out_ready;
  logic [1:0]  credit_req;
  logic [31:0] in_data;
  logic        in_ready, out_valid, out_posted;
  logic [31:0] out_data;
  logic [5:0]  credit_cnt;

  int n_chk = 0, n_fail = 0;
  logic [31:0] log_d [0:63];
  int log_n = 0, rd_i = 0;

  always #(CLK_P/2) clk = ~clk;

  np_credit_gate u_dut (
    .clk(clk), .rst(rst), .link_up(link_up), .credit_req(credit_req),
    .in_valid(in_valid), .in_ready(in_ready), .in_posted(in_posted), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_posted(out_posted),
    .out_data(out_data), .credit_cnt(credit_cnt)
  );

  always begin
    @(negedge clk); #2;
    if (out_valid && out_ready && log_n < 64) begin
      log_d[log_n] = out_data;
      log_n++;
    end
  end

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic give(logic [1:0] code, int n);
    credit_req = code;
    wait_cyc(n);
    credit_req = 2'b00;
  endtask

  task automatic send(logic [31:0] d, logic p);
    bit acc;
    in_valid = 1'b1; in_posted = p; in_data = d;
    do begin
      #1 acc = in_ready;
      @(negedge clk);
    end while (!acc);
    in_valid = 1'b0;
  endtask

  task automatic expect_out(logic [31:0] exp, string req);
    if (rd_i < log_n) begin
      check(log_d[rd_i] == exp, req, int'(log_d[rd_i]), int'(exp));
      rd_i++;
    end else begin
      check(1'b0, req, -1, int'(exp));
    end
  endtask

  task automatic t_reset();
    check(credit_cnt == 0, "R6 count", int'(credit_cnt), 0);
    check(out_valid == 0, "R6 out_valid", int'(out_valid), 0);
  endtask

  task automatic t_codes();
    give(2'b01, 1); check(credit_cnt == 1, "R1 code01", int'(credit_cnt), 1);
    give(2'b10, 1); check(credit_cnt == 3, "R1 code10", int'(credit_cnt), 3);
    give(2'b11, 1); check(credit_cnt == 5, "R1 code11", int'(credit_cnt), 5);
    give(2'b00, 3); check(credit_cnt == 5, "R1 code00", int'(credit_cnt), 5);
  endtask

  task automatic t_saturate();
    give(2'b11, 17); check(credit_cnt == 32, "R2 cap", int'(credit_cnt), 32);
    give(2'b01, 1);  check(credit_cnt == 32, "R2 cap hold", int'(credit_cnt), 32);
    // R2: sum first, then cap: 32 + 1 - 1 stays 32
    credit_req = 2'b01;
    send(32'hD0, 1'b0);
    wait_cyc(4);
    credit_req = 2'b00;
    wait_cyc(1);
    check(credit_cnt == 32, "R2 sum then cap", int'(credit_cnt), 32);
    expect_out(32'hD0, "R2 delivered");
  endtask

  task automatic t_link_drop();
    link_up = 1'b0; credit_req = 2'b11;
    wait_cyc(1);
    check(credit_cnt == 0, "R7 clear", int'(credit_cnt), 0);
    wait_cyc(1);
    check(credit_cnt == 0, "R7 code ignored", int'(credit_cnt), 0);
    credit_req = 2'b00; link_up = 1'b1;
    wait_cyc(1);
  endtask

  task automatic t_np_stall();
    int base;
    base = log_n;
    send(32'h100, 1'b0);
    send(32'h1A1, 1'b1);
    send(32'h1A2, 1'b1);
    wait_cyc(3);
    check(log_n - base == 2, "R5 posted passed", log_n - base, 2);
    expect_out(32'h1A1, "R5 first posted");
    expect_out(32'h1A2, "R5 second posted");
    check(out_valid == 0, "R4 held at zero", int'(out_valid), 0);
    give(2'b01, 1);
    wait_cyc(3);
    expect_out(32'h100, "R4 released");
    check(credit_cnt == 0, "R3 decrement", int'(credit_cnt), 0);
  endtask

  task automatic t_order();
    give(2'b10, 2); give(2'b01, 1);
    check(credit_cnt == 5, "R1 preload", int'(credit_cnt), 5);
    send(32'h301, 1'b0); send(32'h302, 1'b0); send(32'h303, 1'b0);
    wait_cyc(5);
    check(credit_cnt == 2, "R3 three taken", int'(credit_cnt), 2);
    expect_out(32'h301, "R9 order 0");
    expect_out(32'h302, "R9 order 1");
    expect_out(32'h303, "R9 order 2");
  endtask

  task automatic t_fill();
    link_up = 1'b0; wait_cyc(1); link_up = 1'b1; wait_cyc(1);
    for (int i = 0; i < 4; i++) send(32'h200 + i, 1'b0);
    in_valid = 1'b1; in_posted = 1'b0; in_data = 32'h204;
    #1 check(in_ready == 0, "R4 queue full", int'(in_ready), 0);
    in_valid = 1'b0;
    @(negedge clk);
    send(32'h2F0, 1'b1);
    wait_cyc(2);
    expect_out(32'h2F0, "R5 overtake full queue");
    give(2'b11, 2);
    wait_cyc(6);
    for (int i = 0; i < 4; i++) expect_out(32'h200 + i, "R9 drain order");
    check(credit_cnt == 0, "R3 drained", int'(credit_cnt), 0);
  endtask

  task automatic t_backpressure();
    out_ready = 1'b0;
    send(32'h55, 1'b1);
    check(out_valid == 1 && out_data == 32'h55, "R8 loaded", int'(out_data), 32'h55);
    wait_cyc(3);
    check(out_valid == 1 && out_data == 32'h55 && out_posted == 1, "R8 held", int'(out_data), 32'h55);
    in_valid = 1'b1; in_posted = 1'b1; in_data = 32'h66;
    #1 check(in_ready == 0, "R8 no accept", int'(in_ready), 0);
    in_valid = 1'b0;
    @(negedge clk);
    out_ready = 1'b1;
    wait_cyc(2);
    expect_out(32'h55, "R8 released");
    check(out_valid == 0, "R8 slot empty", int'(out_valid), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL all: watchdog expired actual 0 expected 1");
    summary();
    $finish;
  end

  initial begin
    rst = 1'b1; link_up = 1'b1; credit_req = 2'b00; in_valid = 1'b0;
    in_posted = 1'b0; in_data = '0; out_ready = 1'b1;
    wait_cyc(3);
    rst = 1'b0;
    wait_cyc(1);
    t_reset();
    t_codes();
    t_saturate();
    t_link_drop();
    t_np_stall();
    t_order();
    t_fill();
    t_backpressure();
    summary();
    $finish;
  end
endmodule